// File: doc/BRIEF.md
# Protected Pin-Function Port Controller

This block owns a group of 8-pin I/O ports and sits behind a plain register bus. For every pin it keeps a two-bit direction field, an output data bit, a mode bit and a function-select byte. In general-purpose mode a pin is driven from its output data bit. In peripheral mode the pad follows the output and output-enable of the peripheral function that the low bits of the function-select byte pick. Pad inputs pass through a two-flop synchronizer before software can read them.

The function-select bytes decide which peripheral owns a pin, so writes to them are gated by a protect register. Software must first clear the bit-write-disable flag and then set the function-write-enable flag. Locking again takes the same two steps in reverse. A write to a function-select byte while the block is locked is discarded without any notice.

Top module: `pinfunc_ctrl`

## Requirements
- R1: After reset the protect register reads 0x80, every direction field, output bit, mode bit and function byte is 0, and no pad output enable is asserted.
- R2: The direction register of port p is 16 bits wide at byte address 2*p. Pin b owns bits [2b+1:2b], with 00 = unused (input buffer off), 10 = input and 11 = output. A written value reads back unchanged.
- R3: The output data byte of port p is at 0x40+p, one bit per pin at bit b. In general-purpose mode the bit drives pad_o of that pin.
- R4: With the mode bit at 0, a pad output enable is asserted only when the pin's direction field is 11. Fields 00, 01 and 10 keep it low.
- R5: The input byte of port p at 0x60+p returns pad values after a two-flop synchronizer. A pad change shows up in the third read issued from the cycle of the change onward. A pin whose direction field has bit 1 clear reads 0. Writes to this address have no effect.
- R6: The mode byte of port p is at 0x80+p. A 1 at bit b hands pin b to a peripheral. pad_o and pad_oe then take periph_o and periph_oe at index pin*NUM_FUNC + f, where f is bits [2:0] of the function byte. The direction field and the output data bit no longer matter.
- R7: The function byte of linear pin i (i = 8*port + pin) is at 0x200+i. It changes only when written while the enable flag (bit 6 of 0x2FF) is 1. Otherwise the old value stays.
- R8: The protect register at 0x2FF holds a disable flag in bit 7 and an enable flag in bit 6. Every write loads bit 7. Bit 6 is loaded only when the stored bit 7 is 0 and the written bit 7 is 0. Writing 0x00 then 0x40 unlocks, writing 0x00 then 0x80 relocks, and writing 0xC0 leaves bit 6 as it was.
- R9: Read data appears on bus_rdata on the clock after the read request is accepted. Byte registers are zero-extended, and unmapped addresses read 0.
- R10: pin_func_o exports all 8 bits of every pin's stored function byte, including the interrupt-select flag in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 16 | Write data; byte registers use [7:0] |
| bus_rdata | output | 16 | Read data, one cycle after request |
| pad_i | input | NUM_PORTS*8 | Raw pad input levels |
| pad_o | output | NUM_PORTS*8 | Pad output levels |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| periph_o | input | NUM_PORTS*8*NUM_FUNC | Peripheral outputs, per pin and function |
| periph_oe | input | NUM_PORTS*8*NUM_FUNC | Peripheral output enables, per pin and function |
| pin_func_o | output | NUM_PORTS*8*8 | Stored function byte of each pin |

## Verification
The assertions assume that pad_i may change in any cycle, but that bus_addr, bus_we and bus_wdata stay steady whenever bus_en is high at a clock edge. They also assume the synchronizer check only applies once two clean cycles have passed after reset. The bench changes every input at the falling edge and holds each request for exactly one rising edge. It drives the protect register only with the sequences and illegal combinations that R8 names, so every change of the enable flag follows a cleared disable flag. Peripheral vectors and pads are set directly at the falling edge, so the output mux is observed in a settled state.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the pin-function controller: register bases,
// protect-register bit positions and the direction field encoding.
package pfc_pkg;
    localparam int          PINS_PER_PORT = 8;
    localparam logic [11:0] DIR_BASE      = 12'h000;
    localparam logic [11:0] ODR_BASE      = 12'h040;
    localparam logic [11:0] IDR_BASE      = 12'h060;
    localparam logic [11:0] PMR_BASE      = 12'h080;
    localparam logic [11:0] FSEL_BASE     = 12'h200;
    localparam logic [11:0] WPR_ADDR      = 12'h2FF;
    localparam int          WPR_LOCK_BIT  = 7;
    localparam int          WPR_FWE_BIT   = 6;

    typedef enum logic [1:0] {
        DIR_UNUSED = 2'b00,
        DIR_RSVD   = 2'b01,
        DIR_INPUT  = 2'b10,
        DIR_OUTPUT = 2'b11
    } dir_e;
endpackage

// File: rtl/pfc_wprot.sv
`timescale 1ns/1ps
// Write-protect register. It holds a lock flag (reset 1) and a
// function-write-enable flag (reset 0). Assumes wr_i is a single-cycle
// strobe with wdata_i = written bits {7,6}.
module pfc_wprot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output logic       lock_o,
    output logic       fwe_o
);
    // Update lock on every write; enable only while unlocked and staying unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o <= 1'b1;
            fwe_o  <= 1'b0;
        end else if (wr_i) begin
            lock_o <= wdata_i[1];
            if (!lock_o && !wdata_i[1])
                fwe_o <= wdata_i[0];
        end
    end

    p_fwe_needs_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fwe_o) |-> !$past(lock_o));
endmodule

// File: rtl/pfc_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for the pad inputs. Assumes d_i is asynchronous
// and that a two-cycle latency is acceptable to software.
module pfc_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;
    logic [1:0]       age;

    // Shift the pad value through both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end

    // Count clean cycles after reset so the latency check starts valid.
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= '0;
        else if (age != 2'd2)  age <= age + 2'd1;
    end

    p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pfc_pin_mux.sv
`timescale 1ns/1ps
// Output mux for one pin. It chooses between the GPIO path (data bit,
// enable when the direction is output) and the peripheral path picked by
// the function index. Assumes NUM_FUNC is a power of two.
module pfc_pin_mux
    import pfc_pkg::*;
#(
    parameter int NUM_FUNC = 8,
    parameter int FIDX_W   = 3
) (
    input  logic                mode_i,
    input  logic [1:0]          dir_i,
    input  logic                gpio_out_i,
    input  logic [FIDX_W-1:0]   fidx_i,
    input  logic [NUM_FUNC-1:0] periph_o_i,
    input  logic [NUM_FUNC-1:0] periph_oe_i,
    output logic                pad_o,
    output logic                pad_oe
);
    // Choose the pad driver source from the mode bit.
    always_comb begin
        if (mode_i) begin
            pad_o  = periph_o_i[fidx_i];
            pad_oe = periph_oe_i[fidx_i];
        end else begin
            pad_o  = gpio_out_i;
            pad_oe = (dir_e'(dir_i) == DIR_OUTPUT);
        end
    end
endmodule

// File: rtl/pinfunc_ctrl.sv
`timescale 1ns/1ps
// Pin-function port controller. It decodes the register bus, holds
// direction, output, mode and function-select state, gates function-select
// writes through the protect register, and drives the pads. Assumes
// bus_addr, bus_we and bus_wdata are steady while bus_en is sampled.
module pinfunc_ctrl
    import pfc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_FUNC  = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bus_en,
    input  logic                                   bus_we,
    input  logic [11:0]                            bus_addr,
    input  logic [15:0]                            bus_wdata,
    output logic [15:0]                            bus_rdata,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]     pad_i,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]     pad_o,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]     pad_oe,
    input  logic [NUM_PORTS*PINS_PER_PORT*NUM_FUNC-1:0] periph_o,
    input  logic [NUM_PORTS*PINS_PER_PORT*NUM_FUNC-1:0] periph_oe,
    output logic [NUM_PORTS*PINS_PER_PORT*8-1:0]   pin_func_o
);
    localparam int NPINS  = NUM_PORTS * PINS_PER_PORT;
    localparam int FIDX_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

    logic [15:0]      dir_q  [NUM_PORTS];
    logic [7:0]       odr_q  [NUM_PORTS];
    logic [7:0]       pmr_q  [NUM_PORTS];
    logic [7:0]       fsel_q [NPINS];
    logic [7:0]       idr_v  [NUM_PORTS];
    logic [NPINS-1:0] pad_sync;
    logic             wp_lock, wp_fwe;
    logic             wr_stb, rd_stb, wpr_wr, rd_hit;
    logic [15:0]      rd_next;

    assign wr_stb = bus_en && bus_we;
    assign rd_stb = bus_en && !bus_we;
    assign wpr_wr = wr_stb && (bus_addr == WPR_ADDR);

    pfc_wprot u_wprot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wpr_wr),
        .wdata_i ({bus_wdata[WPR_LOCK_BIT], bus_wdata[WPR_FWE_BIT]}),
        .lock_o  (wp_lock),
        .fwe_o   (wp_fwe)
    );

    pfc_sync2 #(.WIDTH(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_i),
        .q_o   (pad_sync)
    );

    // Register writes for the per-port and per-pin state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                dir_q[p] <= '0;
                odr_q[p] <= '0;
                pmr_q[p] <= '0;
            end
            for (int i = 0; i < NPINS; i++) fsel_q[i] <= '0;
        end else if (wr_stb) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == DIR_BASE + 12'(2 * p)) dir_q[p] <= bus_wdata;
                if (bus_addr == ODR_BASE + 12'(p))     odr_q[p] <= bus_wdata[7:0];
                if (bus_addr == PMR_BASE + 12'(p))     pmr_q[p] <= bus_wdata[7:0];
            end
            for (int i = 0; i < NPINS; i++)
                if (wp_fwe && bus_addr == FSEL_BASE + 12'(i)) fsel_q[i] <= bus_wdata[7:0];
        end
    end

    // Mask synchronized pads by the direction field's input-buffer bit.
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++)
            for (int b = 0; b < PINS_PER_PORT; b++)
                idr_v[p][b] = pad_sync[p*PINS_PER_PORT + b] & dir_q[p][2*b+1];
    end

    // Read-data selection over every mapped address.
    always_comb begin
        rd_next = '0;
        rd_hit  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == DIR_BASE + 12'(2 * p)) begin rd_next = dir_q[p];          rd_hit = 1'b1; end
            if (bus_addr == ODR_BASE + 12'(p))     begin rd_next = {8'h00, odr_q[p]}; rd_hit = 1'b1; end
            if (bus_addr == IDR_BASE + 12'(p))     begin rd_next = {8'h00, idr_v[p]}; rd_hit = 1'b1; end
            if (bus_addr == PMR_BASE + 12'(p))     begin rd_next = {8'h00, pmr_q[p]}; rd_hit = 1'b1; end
        end
        for (int i = 0; i < NPINS; i++)
            if (bus_addr == FSEL_BASE + 12'(i)) begin rd_next = {8'h00, fsel_q[i]}; rd_hit = 1'b1; end
        if (bus_addr == WPR_ADDR) begin
            rd_next = {8'h00, wp_lock, wp_fwe, 6'b0};
            rd_hit  = 1'b1;
        end
    end

    // Register read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_next;
    end

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && !rd_hit) |-> (bus_rdata == 16'h0000));

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            localparam int PRT = g / PINS_PER_PORT;
            localparam int BIT = g % PINS_PER_PORT;

            pfc_pin_mux #(.NUM_FUNC(NUM_FUNC), .FIDX_W(FIDX_W)) u_mux (
                .mode_i      (pmr_q[PRT][BIT]),
                .dir_i       (dir_q[PRT][2*BIT +: 2]),
                .gpio_out_i  (odr_q[PRT][BIT]),
                .fidx_i      (fsel_q[g][FIDX_W-1:0]),
                .periph_o_i  (periph_o[g*NUM_FUNC +: NUM_FUNC]),
                .periph_oe_i (periph_oe[g*NUM_FUNC +: NUM_FUNC]),
                .pad_o       (pad_o[g]),
                .pad_oe      (pad_oe[g])
            );

            assign pin_func_o[g*8 +: 8] = fsel_q[g];

            p_fsel_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(fsel_q[g]) |-> $past(wp_fwe));

            p_gpio_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!pmr_q[PRT][BIT] && dir_q[PRT][2*BIT +: 2] != 2'b11) |-> !pad_oe[g]);
        end
    endgenerate
endmodule

// File: tb/test_pinfunc_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: a table of write/read-back vectors, then directed
// tests for reset, protection, output muxing and input synchronization.
module test_pinfunc_ctrl;
    localparam int NP = 4;
    localparam int NF = 8;
    localparam int NPINS = NP * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NPINS-1:0] pad_i = '0, pad_o, pad_oe;
    logic [NPINS*NF-1:0] periph_o = '0, periph_oe = '0;
    logic [NPINS*8-1:0] pin_func_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    pinfunc_ctrl #(.NUM_PORTS(NP), .NUM_FUNC(NF)) i_pinfunc_ctrl (
        .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .pad_i, .pad_o, .pad_oe, .periph_o, .periph_oe, .pin_func_o
    );

    // {address, write data, expected read-back}
    localparam logic [43:0] VEC [8] = '{
        {12'h000, 16'hBEEF, 16'hBEEF},  // R2 port 0 direction
        {12'h006, 16'h1234, 16'h1234},  // R2 port 3 direction
        {12'h041, 16'hAA5A, 16'h005A},  // R3 output byte, zero-extended
        {12'h082, 16'h00C3, 16'h00C3},  // R6 mode byte
        {12'h209, 16'h0077, 16'h0000},  // R7 locked write dropped
        {12'h060, 16'h00FF, 16'h0000},  // R5 input byte ignores writes
        {12'h100, 16'hFFFF, 16'h0000},  // R9 unmapped
        {12'h2FF, 16'h00C0, 16'h0080}   // R8 both bits set: enable unchanged
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #500000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(12'h2FF, rd); check("R1 protect", rd, 16'h0080);
        bus_read(12'h002, rd); check("R1 direction", rd, 16'h0000);
        bus_read(12'h081, rd); check("R1 mode", rd, 16'h0000);
        check("R1 pad_oe", pad_oe, '0);
        check("R1 func bytes", 32'(pin_func_o[63:0] != 0), 32'd0);

        // Vector table
        foreach (VEC[k]) begin
            bus_write(VEC[k][43:32], VEC[k][31:16]);
            bus_read(VEC[k][43:32], rd);
            check($sformatf("R2/R3/R5/R6/R7/R8/R9 vector %0d", k), rd, VEC[k][15:0]);
        end

        // R8/R7 unlock, write, relock, blocked write
        bus_write(12'h2FF, 16'h0000);
        bus_write(12'h2FF, 16'h0040);
        bus_read(12'h2FF, rd); check("R8 unlocked", rd, 16'h0040);
        bus_write(12'h209, 16'h0045);
        bus_read(12'h209, rd); check("R7 write while enabled", rd, 16'h0045);
        check("R10 pin_func_o pin 9", pin_func_o[9*8 +: 8], 8'h45);
        bus_write(12'h2FF, 16'h0000);
        bus_write(12'h2FF, 16'h0080);
        bus_read(12'h2FF, rd); check("R8 relocked", rd, 16'h0080);
        bus_write(12'h209, 16'h0011);
        bus_read(12'h209, rd); check("R7 write while locked", rd, 16'h0045);
        bus_write(12'h2FF, 16'h0040);
        bus_read(12'h2FF, rd); check("R8 enable needs cleared lock", rd, 16'h0000);
        bus_write(12'h2FF, 16'h0080);

        // R4/R3 port 1: pin0=11, pin1=10, pin2=00, pin3=01
        bus_write(12'h002, 16'h004B);
        bus_write(12'h041, 16'h000F);
        check("R4 oe only for field 11", pad_oe[15:8], 8'h01);
        check("R3 pad_o follows data", pad_o[15:8], 8'h0F);

        // R5 input masking and synchronizer latency
        pad_i[15:8] = 8'hFF;
        repeat (3) @(negedge clk);
        bus_read(12'h061, rd); check("R5 masked input", rd, 16'h0003);
        pad_i[8] = 1'b0;
        bus_read(12'h061, rd); check("R5 latency first read", rd, 16'h0003);
        bus_read(12'h061, rd); check("R5 latency second read", rd, 16'h0003);
        bus_read(12'h061, rd); check("R5 latency third read", rd, 16'h0002);

        // R6 peripheral path on pin 10 with function index 5
        bus_write(12'h2FF, 16'h0000);
        bus_write(12'h2FF, 16'h0040);
        bus_write(12'h20A, 16'h0045);
        bus_write(12'h2FF, 16'h0000);
        bus_write(12'h2FF, 16'h0080);
        bus_write(12'h081, 16'h0004);
        periph_o[10*NF + 5]  = 1'b1;
        periph_oe[10*NF + 5] = 1'b1;
        #1;
        check("R6 peripheral oe", pad_oe[15:8], 8'h05);
        check("R6 peripheral out", pad_o[10], 1'b1);
        periph_oe[10*NF + 5] = 1'b0;
        periph_oe[10*NF + 4] = 1'b1;
        periph_o[10*NF + 5]  = 1'b0;
        #1;
        check("R6 index selects function 5", pad_oe[15:8], 8'h01);
        check("R6 output from function 5", pad_o[10], 1'b0);
        check("R10 interrupt flag exported", pin_func_o[10*8 +: 8], 8'h45);

        report();
        $finish;
    end
endmodule